// File: doc/BRIEF.md
# Split-Space Self-Synchronizing Scrambler Pair

This block whitens a link's character stream while keeping every character in its own class. The transmit half sits in front of an 8b10b encoder. It scrambles data characters across all eight bits with one self-synchronizing scrambler. It scrambles the three-bit y field of K28.y specials with a second, independent scrambler, so the encoder still sees legal characters and keeps control of running disparity. The receive half sits after the 8b10b decoder and inverts both scramblers. Its state is built only from received characters, so it falls into step with the transmitter after a few characters of each class and needs no training sequence.

Each clock carries a word of `LANES` characters. The default of four gives a 32-bit path at 125 MHz for a 5 Gbps link. Lane 0 is the oldest character in the word. The scrambler state is threaded through the lanes within one cycle, so every lane's result comes from the registered state by parallel logic. The receiver marks each output lane as trustworthy or not, based on how much history of that lane's class it has seen since reset.

Top module: `sscr_pair`

## Requirements
- R1: Each character is an 8-bit value plus a special flag, packed per lane (lane g in bits 8g+7..8g). The special flag of every output lane equals the flag of the matching input lane, in both directions.
- R2: The data transmit scrambler starts from state zero. For each data character it processes bits LSB first: scrambled bit = input bit XOR s[22] XOR s[17], and then the 23-bit state shifts left, taking the scrambled bit into s[0].
- R3: A special character whose low five bits are 28 is K28.y, with y in bits 7..5. An input y of 7 is replaced by 5 first. Key k = {s6^s5, s5^s4, s4^s3} from the 7-bit special state, with 7 read as 0. The output y is (y + k + 1) mod 7, so it is never 7. The state shifts left by three bits, taking in the output y.
- R4: Specials that are not K28.0 to K28.6 pass through unchanged and do not advance any state. At the receiver, K28.7 belongs to this group.
- R5: A scrambler state changes only on characters of its own class. Within a word, lanes are processed in order from lane 0 upward.
- R6: Output valid follows input valid one cycle later in each direction. A word with valid low changes neither the states nor the output values.
- R7: The receive descrambler inverts R2 and R3, shifting the received bits or y values into its own states. When it is fed the transmit output, it returns the transmit input, with K28.7 shown as K28.5.
- R8: Whatever state the receiver holds, once 3 data characters and 3 K28 characters of a looped-back stream have passed, all later outputs of that class equal the plaintext.
- R9: The lock flag of a receive lane is 1 when that lane's class already has at least 3 earlier characters since reset (3 data or 3 K28), and 1 for a pass-through special. Otherwise it is 0.
- R10: Under reset, both output valids, all output data, special flags and lock flags are 0, and all states and counts clear.
- R11: A transmit input made only of K28.5 produces at least three distinct output y values over 30 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Transmit word valid |
| tx_in_data | input | LANES*8 | Transmit plaintext characters |
| tx_in_k | input | LANES | Special flag per transmit lane |
| tx_out_valid | output | 1 | Scrambled word valid |
| tx_out_data | output | LANES*8 | Scrambled characters to the encoder |
| tx_out_k | output | LANES | Special flag per scrambled lane |
| rx_in_valid | input | 1 | Received word valid |
| rx_in_data | input | LANES*8 | Characters from the decoder |
| rx_in_k | input | LANES | Special flag per received lane |
| rx_out_valid | output | 1 | Descrambled word valid |
| rx_out_data | output | LANES*8 | Descrambled characters |
| rx_out_k | output | LANES | Special flag per descrambled lane |
| rx_out_lock | output | LANES | Lane result comes from a filled state |

## Verification
The bench builds the block with LANES = 4. With four lanes, data, K28 and pass-through characters are interleaved inside one word, so the state threading between lanes is exercised in a single cycle. The lock threshold of three characters is reached partway through a word, which makes the per-lane lock flag differ between lanes of the same word. It first drives the receiver with unrelated traffic and then switches it to a loopback of the transmit output, so resynchronization from an arbitrary state is observed.

// File: rtl/sscr_pkg.sv
package sscr_pkg;

    localparam int CHAR_W = 8;
    localparam int X_W    = 5;
    localparam int Y_W    = 3;
    localparam logic [X_W-1:0] K28_X    = 5'd28;
    localparam logic [Y_W-1:0] Y_BANNED = 3'd7;
    localparam logic [Y_W-1:0] Y_SUBST  = 3'd5;
    localparam int Y_SPAN = 7;

    // data scrambler: x^23 + x^18 + 1
    localparam int DS_W  = 23;
    localparam int DS_TA = 22;
    localparam int DS_TB = 17;
    // special scrambler: x^7 + x^6 + 1, three bits in per character
    localparam int KS_W  = 7;

    localparam int D_LOCK   = (DS_W + CHAR_W - 1) / CHAR_W;
    localparam int K_LOCK   = (KS_W + Y_W - 1) / Y_W;
    localparam int LOCK_MAX = (D_LOCK > K_LOCK) ? D_LOCK : K_LOCK;
    localparam int CNT_W    = $clog2(LOCK_MAX + 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [DS_W-1:0]  dstate_t;
    typedef logic [KS_W-1:0]  kstate_t;

    typedef enum logic [1:0] {CLS_DATA, CLS_K28, CLS_PASS} cls_t;

    typedef struct packed {
        logic [CHAR_W-1:0] val;
        logic              is_k;
    } char_t;

    typedef struct packed {
        dstate_t d;
        kstate_t k;
    } st_t;

    typedef struct packed {
        logic [CHAR_W-1:0] v;
        dstate_t           s;
    } dres_t;

    typedef struct packed {
        logic [Y_W-1:0] y;
        kstate_t        s;
    } kres_t;

    // tx_side: K28.7 is accepted (and substituted) only on the transmit side
    function automatic cls_t classify(char_t c, logic tx_side);
        if (!c.is_k)
            return CLS_DATA;
        if (c.val[X_W-1:0] == K28_X &&
            (tx_side || c.val[CHAR_W-1 -: Y_W] != Y_BANNED))
            return CLS_K28;
        return CLS_PASS;
    endfunction

    function automatic dres_t d_scr(logic [CHAR_W-1:0] d, dstate_t s_in);
        dres_t   r;
        dstate_t s;
        s = s_in;
        r.v = '0;
        for (int b = 0; b < CHAR_W; b++) begin
            r.v[b] = d[b] ^ s[DS_TA] ^ s[DS_TB];
            s = {s[DS_W-2:0], r.v[b]};
        end
        r.s = s;
        return r;
    endfunction

    function automatic dres_t d_dscr(logic [CHAR_W-1:0] d, dstate_t s_in);
        dres_t   r;
        dstate_t s;
        s = s_in;
        r.v = '0;
        for (int b = 0; b < CHAR_W; b++) begin
            r.v[b] = d[b] ^ s[DS_TA] ^ s[DS_TB];
            s = {s[DS_W-2:0], d[b]};
        end
        r.s = s;
        return r;
    endfunction

    function automatic logic [Y_W-1:0] k_key(kstate_t s);
        logic [Y_W-1:0] raw;
        raw = s[KS_W-1 -: Y_W] ^ s[KS_W-2 -: Y_W];
        return (raw == Y_BANNED) ? '0 : raw;
    endfunction

    function automatic logic [Y_W-1:0] y_fwd(logic [Y_W-1:0] y, logic [Y_W-1:0] key);
        logic [4:0] t;
        t = 5'(y) + 5'(key) + 5'd1;
        if (t >= 5'(Y_SPAN))
            t = t - 5'(Y_SPAN);
        if (t >= 5'(Y_SPAN))
            t = t - 5'(Y_SPAN);
        return t[Y_W-1:0];
    endfunction

    function automatic logic [Y_W-1:0] y_rev(logic [Y_W-1:0] r, logic [Y_W-1:0] key);
        logic [4:0] t;
        t = 5'(r) + 5'(2 * Y_SPAN - 1) - 5'(key);
        if (t >= 5'(2 * Y_SPAN))
            t = t - 5'(2 * Y_SPAN);
        if (t >= 5'(Y_SPAN))
            t = t - 5'(Y_SPAN);
        return t[Y_W-1:0];
    endfunction

    function automatic kres_t k_scr(logic [Y_W-1:0] y, kstate_t s);
        kres_t r;
        r.y = y_fwd(y, k_key(s));
        r.s = {s[KS_W-Y_W-1:0], r.y};
        return r;
    endfunction

    function automatic kres_t k_dscr(logic [Y_W-1:0] y, kstate_t s);
        kres_t r;
        r.y = y_rev(y, k_key(s));
        r.s = {s[KS_W-Y_W-1:0], y};
        return r;
    endfunction

endpackage

// File: rtl/sscr_tx_lane.sv
module sscr_tx_lane
    import sscr_pkg::*;
(
    input  char_t ch_i,
    input  st_t   st_i,
    output char_t ch_o,
    output st_t   st_o
);

    dres_t          dr;
    kres_t          kr;
    logic [Y_W-1:0] y_in;

    always_comb begin
        ch_o = ch_i;
        st_o = st_i;
        dr   = '0;
        kr   = '0;
        y_in = (ch_i.val[CHAR_W-1 -: Y_W] == Y_BANNED) ? Y_SUBST
                                                        : ch_i.val[CHAR_W-1 -: Y_W];
        case (classify(ch_i, 1'b1))
            CLS_DATA: begin
                dr       = d_scr(ch_i.val, st_i.d);
                ch_o.val = dr.v;
                st_o.d   = dr.s;
            end
            CLS_K28: begin
                kr       = k_scr(y_in, st_i.k);
                ch_o.val = {kr.y, K28_X};
                st_o.k   = kr.s;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sscr_rx_lane.sv
module sscr_rx_lane
    import sscr_pkg::*;
(
    input  char_t ch_i,
    input  st_t   st_i,
    input  cnt_t  cd_i,
    input  cnt_t  ck_i,
    output char_t ch_o,
    output st_t   st_o,
    output cnt_t  cd_o,
    output cnt_t  ck_o,
    output logic  lock_o
);

    dres_t dr;
    kres_t kr;

    always_comb begin
        ch_o   = ch_i;
        st_o   = st_i;
        cd_o   = cd_i;
        ck_o   = ck_i;
        lock_o = 1'b1;
        dr     = '0;
        kr     = '0;
        case (classify(ch_i, 1'b0))
            CLS_DATA: begin
                dr       = d_dscr(ch_i.val, st_i.d);
                ch_o.val = dr.v;
                st_o.d   = dr.s;
                lock_o   = (cd_i >= cnt_t'(D_LOCK));
                if (cd_i < cnt_t'(D_LOCK))
                    cd_o = cd_i + 1'b1;
            end
            CLS_K28: begin
                kr       = k_dscr(ch_i.val[CHAR_W-1 -: Y_W], st_i.k);
                ch_o.val = {kr.y, K28_X};
                st_o.k   = kr.s;
                lock_o   = (ck_i >= cnt_t'(K_LOCK));
                if (ck_i < cnt_t'(K_LOCK))
                    ck_o = ck_i + 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sscr_tx_path.sv
module sscr_tx_path
    import sscr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  char_t [LANES-1:0]   in_ch,
    output logic                out_valid,
    output char_t [LANES-1:0]   out_ch
);

    st_t              st_q;
    st_t              chain [LANES+1];
    char_t [LANES-1:0] lane_ch;

    assign chain[0] = st_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sscr_tx_lane lane_i (
            .ch_i (in_ch[g]),
            .st_i (chain[g]),
            .ch_o (lane_ch[g]),
            .st_o (chain[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            out_valid <= 1'b0;
            out_ch    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                st_q   <= chain[LANES];
                out_ch <= lane_ch;
            end
        end
    end

endmodule

// File: rtl/sscr_rx_path.sv
module sscr_rx_path
    import sscr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  char_t [LANES-1:0]   in_ch,
    output logic                out_valid,
    output char_t [LANES-1:0]   out_ch,
    output logic [LANES-1:0]    out_lock
);

    st_t               st_q;
    cnt_t              cd_q;
    cnt_t              ck_q;
    st_t               chain [LANES+1];
    cnt_t              cd_chain [LANES+1];
    cnt_t              ck_chain [LANES+1];
    char_t [LANES-1:0] lane_ch;
    logic [LANES-1:0]  lane_lock;

    assign chain[0]    = st_q;
    assign cd_chain[0] = cd_q;
    assign ck_chain[0] = ck_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sscr_rx_lane lane_i (
            .ch_i   (in_ch[g]),
            .st_i   (chain[g]),
            .cd_i   (cd_chain[g]),
            .ck_i   (ck_chain[g]),
            .ch_o   (lane_ch[g]),
            .st_o   (chain[g+1]),
            .cd_o   (cd_chain[g+1]),
            .ck_o   (ck_chain[g+1]),
            .lock_o (lane_lock[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            cd_q      <= '0;
            ck_q      <= '0;
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_lock  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                st_q     <= chain[LANES];
                cd_q     <= cd_chain[LANES];
                ck_q     <= ck_chain[LANES];
                out_ch   <= lane_ch;
                out_lock <= lane_lock;
            end
        end
    end

endmodule

// File: rtl/sscr_pair.sv
module sscr_pair
    import sscr_pkg::*;
#(
    parameter int LANES = 4,
    localparam int W = LANES * CHAR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_in_valid,
    input  logic [W-1:0]     tx_in_data,
    input  logic [LANES-1:0] tx_in_k,
    output logic             tx_out_valid,
    output logic [W-1:0]     tx_out_data,
    output logic [LANES-1:0] tx_out_k,
    input  logic             rx_in_valid,
    input  logic [W-1:0]     rx_in_data,
    input  logic [LANES-1:0] rx_in_k,
    output logic             rx_out_valid,
    output logic [W-1:0]     rx_out_data,
    output logic [LANES-1:0] rx_out_k,
    output logic [LANES-1:0] rx_out_lock
);

    char_t [LANES-1:0] tx_ch_in;
    char_t [LANES-1:0] tx_ch_out;
    char_t [LANES-1:0] rx_ch_in;
    char_t [LANES-1:0] rx_ch_out;

    for (genvar g = 0; g < LANES; g++) begin : g_map
        assign tx_ch_in[g] = {tx_in_data[g*CHAR_W +: CHAR_W], tx_in_k[g]};
        assign rx_ch_in[g] = {rx_in_data[g*CHAR_W +: CHAR_W], rx_in_k[g]};
        assign tx_out_data[g*CHAR_W +: CHAR_W] = tx_ch_out[g].val;
        assign tx_out_k[g]                     = tx_ch_out[g].is_k;
        assign rx_out_data[g*CHAR_W +: CHAR_W] = rx_ch_out[g].val;
        assign rx_out_k[g]                     = rx_ch_out[g].is_k;
    end

    sscr_tx_path #(.LANES(LANES)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_in_valid),
        .in_ch     (tx_ch_in),
        .out_valid (tx_out_valid),
        .out_ch    (tx_ch_out)
    );

    sscr_rx_path #(.LANES(LANES)) rx_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_in_valid),
        .in_ch     (rx_ch_in),
        .out_valid (rx_out_valid),
        .out_ch    (rx_ch_out),
        .out_lock  (rx_out_lock)
    );

endmodule

// File: rtl/sscr_pair_chk.sv
module sscr_pair_chk #(
    parameter int LANES = 4,
    localparam int W = LANES * 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_in_valid,
    input logic [W-1:0]     tx_in_data,
    input logic [LANES-1:0] tx_in_k,
    input logic             tx_out_valid,
    input logic [W-1:0]     tx_out_data,
    input logic [LANES-1:0] tx_out_k,
    input logic             rx_in_valid,
    input logic [W-1:0]     rx_in_data,
    input logic [LANES-1:0] rx_in_k,
    input logic             rx_out_valid,
    input logic [LANES-1:0] rx_out_k,
    input logic [LANES-1:0] rx_out_lock
);

    p_tx_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
        tx_in_valid |=> tx_out_valid);
    p_tx_idle_follow_r6: assert property (@(posedge clk) disable iff (rst)
        !tx_in_valid |=> (!tx_out_valid && $stable(tx_out_data)));
    p_rx_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
        rx_in_valid |=> rx_out_valid);
    p_rx_idle_follow_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_in_valid |=> !rx_out_valid);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        p_tx_class_kept_r1: assert property (@(posedge clk) disable iff (rst)
            tx_in_valid |=> (tx_out_k[i] == $past(tx_in_k[i])));
        p_rx_class_kept_r1: assert property (@(posedge clk) disable iff (rst)
            rx_in_valid |=> (rx_out_k[i] == $past(rx_in_k[i])));
        p_no_k28_7_r3: assert property (@(posedge clk) disable iff (rst)
            (tx_out_valid && tx_out_k[i] && tx_out_data[i*8 +: 5] == 5'd28)
            |-> (tx_out_data[i*8+5 +: 3] != 3'd7));
        p_other_pass_r4: assert property (@(posedge clk) disable iff (rst)
            (tx_in_valid && tx_in_k[i] && tx_in_data[i*8 +: 5] != 5'd28)
            |=> (tx_out_data[i*8 +: 8] == $past(tx_in_data[i*8 +: 8])));
        p_pass_lock_r9: assert property (@(posedge clk) disable iff (rst)
            (rx_in_valid && rx_in_k[i] &&
             (rx_in_data[i*8 +: 5] != 5'd28 || rx_in_data[i*8+5 +: 3] == 3'd7))
            |=> rx_out_lock[i]);
    end

endmodule

bind sscr_pair sscr_pair_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/sscr_pair_tb_top.sv
module sscr_pair_tb_top;

    localparam int LANES = 4;
    localparam int W     = LANES * 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             tx_in_valid, tx_out_valid, rx_in_valid, rx_out_valid;
    logic [W-1:0]     tx_in_data, tx_out_data, rx_in_data, rx_out_data;
    logic [LANES-1:0] tx_in_k, tx_out_k, rx_in_k, rx_out_k, rx_out_lock;

    always #4 clk = ~clk;

    sscr_pair #(.LANES(LANES)) dut_i (
        .clk(clk), .rst(rst),
        .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_k(tx_in_k),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_k(tx_out_k),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_k(rx_in_k),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_k(rx_out_k),
        .rx_out_lock(rx_out_lock)
    );

    int checks = 0;
    int errors = 0;

    // bench reference state
    logic [22:0] m_td, m_rd;
    logic [6:0]  m_tk, m_rk;
    int          m_cd, m_ck;

    // stimulus and expectations per lane
    logic [7:0] s_tv [LANES];
    logic       s_tk [LANES];
    logic [7:0] s_rv [LANES];
    logic       s_rk [LANES];
    logic [7:0] e_tv [LANES];
    logic [7:0] e_rv [LANES];
    logic       e_rl [LANES];
    logic [7:0] pl_now [LANES];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] mkey(logic [6:0] s);
        logic [6:0] x;
        x = (s >> 4) ^ (s >> 3);
        return (x[2:0] == 3'd7) ? 3'd0 : x[2:0];
    endfunction

    function automatic logic [7:0] gen_val(output logic k);
        int r;
        r = int'($urandom % 10);
        if (r < 6) begin
            k = 1'b0;
            return 8'($urandom);
        end else if (r < 9) begin
            k = 1'b1;
            return {3'($urandom), 5'd28};
        end else begin
            k = 1'b1;
            case ($urandom % 4)
                0: return 8'hF7;
                1: return 8'hFB;
                2: return 8'hFD;
                default: return 8'hFE;
            endcase
        end
    endfunction

    task automatic mdl_tx(input int g);
        int y, ny;
        logic [7:0] o;
        if (!s_tk[g]) begin
            o = '0;
            for (int b = 0; b < 8; b++) begin
                o[b] = s_tv[g][b] ^ m_td[22] ^ m_td[17];
                m_td = {m_td[21:0], o[b]};
            end
            e_tv[g] = o;
            pl_now[g] = s_tv[g];
        end else if (s_tv[g][4:0] == 5'd28) begin
            y = int'(s_tv[g][7:5]);
            if (y == 7) y = 5;
            ny = (y + int'(mkey(m_tk)) + 1) % 7;
            e_tv[g] = {3'(ny), 5'd28};
            pl_now[g] = {3'(y), 5'd28};
            m_tk = {m_tk[3:0], 3'(ny)};
        end else begin
            e_tv[g] = s_tv[g];
            pl_now[g] = s_tv[g];
        end
    endtask

    task automatic mdl_rx(input int g);
        int ny;
        logic [7:0] o;
        if (!s_rk[g]) begin
            o = '0;
            for (int b = 0; b < 8; b++) begin
                o[b] = s_rv[g][b] ^ m_rd[22] ^ m_rd[17];
                m_rd = {m_rd[21:0], s_rv[g][b]};
            end
            e_rv[g] = o;
            e_rl[g] = (m_cd >= 3);
            m_cd++;
        end else if (s_rv[g][4:0] == 5'd28 && s_rv[g][7:5] != 3'd7) begin
            ny = (int'(s_rv[g][7:5]) - int'(mkey(m_rk)) - 1 + 14) % 7;
            e_rv[g] = {3'(ny), 5'd28};
            e_rl[g] = (m_ck >= 3);
            m_rk = {m_rk[3:0], s_rv[g][7:5]};
            m_ck++;
        end else begin
            e_rv[g] = s_rv[g];
            e_rl[g] = 1'b1;
        end
    endtask

    task automatic step(input bit tv, input bit rv);
        logic [W-1:0] prev_tx;
        @(negedge clk);
        prev_tx = tx_out_data;
        tx_in_valid = tv;
        rx_in_valid = rv;
        for (int g = 0; g < LANES; g++) begin
            tx_in_data[g*8 +: 8] = s_tv[g];
            tx_in_k[g]           = s_tk[g];
            rx_in_data[g*8 +: 8] = s_rv[g];
            rx_in_k[g]           = s_rk[g];
            if (tv) mdl_tx(g);
            if (rv) mdl_rx(g);
        end
        @(posedge clk);
        #1;
        chk(tx_out_valid == tv, "R6 tx valid", 32'(tx_out_valid), 32'(tv));
        chk(rx_out_valid == rv, "R6 rx valid", 32'(rx_out_valid), 32'(rv));
        if (!tv)
            chk(tx_out_data == prev_tx, "R6 tx hold", tx_out_data, prev_tx);
        for (int g = 0; g < LANES; g++) begin
            if (tv) begin
                chk(tx_out_k[g] == s_tk[g], "R1 tx class", 32'(tx_out_k[g]), 32'(s_tk[g]));
                chk(tx_out_data[g*8 +: 8] == e_tv[g],
                    !s_tk[g] ? "R2 data scramble" :
                    (s_tv[g][4:0] == 5'd28 ? "R3 K28 scramble" : "R4 pass"),
                    32'(tx_out_data[g*8 +: 8]), 32'(e_tv[g]));
            end
            if (rv) begin
                chk(rx_out_k[g] == s_rk[g], "R1 rx class", 32'(rx_out_k[g]), 32'(s_rk[g]));
                chk(rx_out_data[g*8 +: 8] == e_rv[g], "R7 descramble",
                    32'(rx_out_data[g*8 +: 8]), 32'(e_rv[g]));
                chk(rx_out_lock[g] == e_rl[g], "R9 lock", 32'(rx_out_lock[g]), 32'(e_rl[g]));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] cap_v [LANES];
        logic       cap_k [LANES];
        logic       cap_valid;
        logic [7:0] pl_prev [LANES];
        int         lbd, lbk;
        logic [7:0] seen;

        void'($urandom(32'd4242));
        m_td = '0; m_rd = '0; m_tk = '0; m_rk = '0; m_cd = 0; m_ck = 0;
        rst = 1'b1;
        tx_in_valid = 1'b0; rx_in_valid = 1'b0;
        tx_in_data = '0; rx_in_data = '0; tx_in_k = '0; rx_in_k = '0;
        for (int g = 0; g < LANES; g++) begin
            s_tv[g] = '0; s_tk[g] = 1'b0; s_rv[g] = '0; s_rk[g] = 1'b0;
            cap_v[g] = '0; cap_k[g] = 1'b0; pl_prev[g] = '0;
        end
        cap_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(tx_out_valid == 1'b0 && rx_out_valid == 1'b0, "R10 valid", 32'(tx_out_valid), 0);
        chk(tx_out_data == '0 && rx_out_data == '0, "R10 data", tx_out_data, 0);
        chk(tx_out_k == '0 && rx_out_k == '0, "R10 k", 32'(tx_out_k), 0);
        chk(rx_out_lock == '0, "R10 lock", 32'(rx_out_lock), 0);
        @(negedge clk);
        rst = 1'b0;

        // Phase A: independent random traffic on both sides, some idle words
        for (int n = 0; n < 300; n++) begin
            for (int g = 0; g < LANES; g++) begin
                s_tv[g] = gen_val(s_tk[g]);
                s_rv[g] = gen_val(s_rk[g]);
            end
            step(($urandom % 8) != 0, ($urandom % 8) != 0);
        end

        // R4/R5 directed: a word of only pass-through specials leaves states alone
        for (int g = 0; g < LANES; g++) begin
            s_tv[g] = 8'hF7; s_tk[g] = 1'b1; s_rv[g] = 8'hFC; s_rk[g] = 1'b1;
        end
        step(1'b1, 1'b1);
        for (int g = 0; g < LANES; g++)
            chk(tx_out_data[g*8 +: 8] == 8'hF7, "R4 K23.7 unchanged",
                32'(tx_out_data[g*8 +: 8]), 32'hF7);

        // R3 directed: K28.7 input never leaves as K28.7
        for (int g = 0; g < LANES; g++) begin
            s_tv[g] = 8'hFC; s_tk[g] = 1'b1;
        end
        for (int n = 0; n < 6; n++) begin
            step(1'b1, 1'b0);
            for (int g = 0; g < LANES; g++)
                chk(tx_out_data[g*8+5 +: 3] != 3'd7, "R3 no K28.7",
                    32'(tx_out_data[g*8 +: 8]), 32'hFC);
        end

        // R11 idle K28.5 stream varies
        seen = '0;
        for (int g = 0; g < LANES; g++) begin
            s_tv[g] = 8'hBC; s_tk[g] = 1'b1;
        end
        for (int n = 0; n < 30; n++) begin
            step(1'b1, 1'b0);
            for (int g = 0; g < LANES; g++)
                seen[tx_out_data[g*8+5 +: 3]] = 1'b1;
        end
        chk($countones(seen) >= 3 && !seen[7], "R11 idle variety", 32'(seen), 32'h7F);

        // Phase B: loopback from tx output into rx, receiver starts out of step
        cap_valid = 1'b0;
        lbd = 0; lbk = 0;
        for (int n = 0; n < 300; n++) begin
            for (int g = 0; g < LANES; g++) begin
                s_tv[g] = gen_val(s_tk[g]);
                s_rv[g] = cap_v[g];
                s_rk[g] = cap_k[g];
            end
            step(($urandom % 6) != 0, cap_valid);
            if (cap_valid) begin
                for (int g = 0; g < LANES; g++) begin
                    if (!cap_k[g]) begin
                        if (lbd >= 3)
                            chk(rx_out_data[g*8 +: 8] == pl_prev[g], "R8 data resync",
                                32'(rx_out_data[g*8 +: 8]), 32'(pl_prev[g]));
                        lbd++;
                    end else if (cap_v[g][4:0] == 5'd28) begin
                        if (lbk >= 3)
                            chk(rx_out_data[g*8 +: 8] == pl_prev[g], "R8 K28 resync",
                                32'(rx_out_data[g*8 +: 8]), 32'(pl_prev[g]));
                        lbk++;
                    end else begin
                        chk(rx_out_data[g*8 +: 8] == pl_prev[g], "R7 pass loopback",
                            32'(rx_out_data[g*8 +: 8]), 32'(pl_prev[g]));
                    end
                end
            end
            cap_valid = tx_out_valid;
            if (tx_out_valid) begin
                for (int g = 0; g < LANES; g++) begin
                    cap_v[g]   = tx_out_data[g*8 +: 8];
                    cap_k[g]   = tx_out_k[g];
                    pl_prev[g] = pl_now[g];
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule